// File: doc/BRIEF.md
# Long-Instruction-Word Expansion Unit

This block sits between instruction fetch and issue. It takes a 48-bit program word. When the word's call bit is set, a low index field of the word addresses an on-chip table of 96-bit entries. The selected entry is split into six 16-bit subinstructions, which are issued in parallel. Slots 0 to 3 go to the execution units, two ALUs and two MACs. Slots 4 and 5 go to the memory-access units.

Each execution slot can also be redirected to an accelerator port of the same number. A per-slot routing register decides this. For either slot pair (0/1 or 2/3), a pair-join bit can merge the two subinstructions into one 32-bit accelerator opcode. In that case the upper slot of the pair is issued as a native NOP.

The table is loaded through a write port that can be used at any time. Instructions enter through a valid/ready handshake and leave through another one. A stall input, driven by memory wait states, freezes the block.

Top module: `liw_expand`

## Requirements
- R1: After reset `out_valid_o` and `acc_valid_o` are 0, and `in_ready_o` is 1 while `stall_i` is low.
- R2: A word taken with `in_word_i[47]`=1 produces, after the next clock edge, `out_valid_o`=1 and `out_word_o` equal to the word. Subinstruction k is entry bits [16k+15:16k]. Slots 0..3 appear on `exec_op_o[16k+15:16k]` and slots 4..5 on `mem_op_o`.
- R3: A word with `in_word_i[47]`=0 gives all execution and memory ops equal to NOP (16'h0000) and `acc_valid_o`=0.
- R4: When routing bit k is set, slot k gives `acc_valid_o[k]`=1 and `acc_op_o[32k+31:32k]`={16'h0, sub k}, and `exec_op_o` slot k is NOP. An unrouted slot has `acc_valid_o[k]`=0 and a zero accelerator op.
- R5: Take pair j (slots 2j, 2j+1). When pair bit j and routing bit 2j are both set, port 2j gets {sub 2j+1, sub 2j}. Slot 2j+1 is then a native NOP with `acc_valid_o[2j+1]`=0, whatever its routing bit. A pair bit whose routing bit 2j is clear has no effect.
- R6: Routing and pair settings are sampled when a word is taken. A later configuration write does not alter a bundle already on the outputs.
- R7: While `stall_i` is high, `in_ready_o` is 0 and every output holds its value.
- R8: `in_ready_o` = !stall_i && (!out_valid_o || out_ready_i). A bundle stays on the outputs unchanged until `out_ready_i` is high with `stall_i` low.
- R9: A table write does not disturb a bundle already on the outputs. A later call to the same index returns the new entry.
- R10: Only `in_word_i[IDX_W-1:0]` selects the entry. Other bits below bit 47 do not affect the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write enable |
| tbl_waddr_i | input | IDX_W | Table write index |
| tbl_wdata_i | input | 96 | Table write entry |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_route_i | input | 4 | Per-slot accelerator routing bits |
| cfg_pair_i | input | 2 | Per-pair 32-bit opcode join bits |
| in_valid_i | input | 1 | Program word valid |
| in_ready_o | output | 1 | Program word accepted |
| in_word_i | input | 48 | Program word |
| stall_i | input | 1 | Memory wait state, freezes block |
| out_valid_o | output | 1 | Bundle valid |
| out_ready_i | input | 1 | Issue stage ready |
| out_word_o | output | 48 | Program word of the bundle (operand source) |
| exec_op_o | output | 64 | Native execution ops, slots 0..3 |
| mem_op_o | output | 32 | Memory-access ops, slots 4..5 |
| acc_valid_o | output | 4 | Accelerator port strobes |
| acc_op_o | output | 128 | Accelerator opcodes, 32 bits per port |

## Verification
Every table index is called once with native routing and with unrelated upper word bits set. This tells apart a correct entry lookup and slice order from lookups that depend on the wrong bits. All sixteen routing patterns are then combined with all four pair settings. That separates single-slot redirection from the joined 32-bit case, including the case where the pair bit is inert. Plain words show the NOP bundle. Held bundles are then disturbed by configuration writes, table writes, stalls and withheld ready, to show which events may and may not change the outputs.

// File: rtl/liw_pkg.sv
package liw_pkg;
  localparam int SUB_W   = 16;
  localparam int N_EXEC  = 4;
  localparam int N_MEM   = 2;
  localparam int N_SUB   = N_EXEC + N_MEM;
  localparam int ENTRY_W = N_SUB * SUB_W;
  localparam int WORD_W  = 48;
  localparam int CALL_BIT = WORD_W - 1;
  localparam int ACC_W   = 2 * SUB_W;
  localparam logic [SUB_W-1:0] NOP = '0;
endpackage

// File: rtl/liw_table.sv
module liw_table #(
  parameter int IDX_W = 8,
  parameter int DW    = 96
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/liw_pair_route.sv
module liw_pair_route
  import liw_pkg::*;
(
  input  logic             call_i,
  input  logic [SUB_W-1:0] lo_i,
  input  logic [SUB_W-1:0] hi_i,
  input  logic [1:0]       route_i,
  input  logic             pair_i,
  output logic [SUB_W-1:0] nat_lo_o,
  output logic [SUB_W-1:0] nat_hi_o,
  output logic [1:0]       acc_vld_o,
  output logic [ACC_W-1:0] acc_lo_o,
  output logic [ACC_W-1:0] acc_hi_o
);
  logic joined;
  assign joined = pair_i & route_i[0];

  always_comb begin
    nat_lo_o  = NOP;
    nat_hi_o  = NOP;
    acc_vld_o = '0;
    acc_lo_o  = '0;
    acc_hi_o  = '0;
    if (call_i) begin
      if (route_i[0]) begin
        acc_vld_o[0] = 1'b1;
        acc_lo_o     = joined ? {hi_i, lo_i} : {{SUB_W{1'b0}}, lo_i};
      end else begin
        nat_lo_o = lo_i;
      end
      // upper slot consumed by the joined opcode
      if (!joined) begin
        if (route_i[1]) begin
          acc_vld_o[1] = 1'b1;
          acc_hi_o     = {{SUB_W{1'b0}}, hi_i};
        end else begin
          nat_hi_o = hi_i;
        end
      end
    end
  end
endmodule

// File: rtl/liw_expand.sv
module liw_expand
  import liw_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tbl_we_i,
  input  logic [IDX_W-1:0]        tbl_waddr_i,
  input  logic [ENTRY_W-1:0]      tbl_wdata_i,
  input  logic                    cfg_we_i,
  input  logic [N_EXEC-1:0]       cfg_route_i,
  input  logic [N_EXEC/2-1:0]     cfg_pair_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [WORD_W-1:0]       in_word_i,
  input  logic                    stall_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [WORD_W-1:0]       out_word_o,
  output logic [N_EXEC*SUB_W-1:0] exec_op_o,
  output logic [N_MEM*SUB_W-1:0]  mem_op_o,
  output logic [N_EXEC-1:0]       acc_valid_o,
  output logic [N_EXEC*ACC_W-1:0] acc_op_o
);
  localparam int N_PAIR = N_EXEC / 2;

  logic [N_EXEC-1:0] route_cfg_q, route_q;
  logic [N_PAIR-1:0] pair_cfg_q, pair_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic              accept, take;
  logic [ENTRY_W-1:0] entry;
  logic [N_EXEC-1:0]  acc_vld_raw;

  assign in_ready_o = ~stall_i & (~valid_q | out_ready_i);
  assign accept     = in_valid_i & in_ready_o;
  assign take       = valid_q & out_ready_i & ~stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_cfg_q <= '0;
      pair_cfg_q  <= '0;
    end else if (cfg_we_i) begin
      route_cfg_q <= cfg_route_i;
      pair_cfg_q  <= cfg_pair_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      route_q <= '0;
      pair_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      word_q  <= in_word_i;
      route_q <= route_cfg_q;
      pair_q  <= pair_cfg_q;
    end else if (take) begin
      valid_q <= 1'b0;
    end
  end

  liw_table #(.IDX_W(IDX_W), .DW(ENTRY_W)) u_table (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_waddr_i),
    .wdata_i (tbl_wdata_i),
    .re_i    (accept),
    .raddr_i (in_word_i[IDX_W-1:0]),
    .rdata_o (entry)
  );

  logic call;
  assign call = word_q[CALL_BIT];

  for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
    liw_pair_route u_route (
      .call_i    (call),
      .lo_i      (entry[(2*j)*SUB_W +: SUB_W]),
      .hi_i      (entry[(2*j+1)*SUB_W +: SUB_W]),
      .route_i   (route_q[2*j +: 2]),
      .pair_i    (pair_q[j]),
      .nat_lo_o  (exec_op_o[(2*j)*SUB_W +: SUB_W]),
      .nat_hi_o  (exec_op_o[(2*j+1)*SUB_W +: SUB_W]),
      .acc_vld_o (acc_vld_raw[2*j +: 2]),
      .acc_lo_o  (acc_op_o[(2*j)*ACC_W +: ACC_W]),
      .acc_hi_o  (acc_op_o[(2*j+1)*ACC_W +: ACC_W])
    );
  end

  for (genvar m = 0; m < N_MEM; m++) begin : g_mem
    assign mem_op_o[m*SUB_W +: SUB_W] = call ? entry[(N_EXEC+m)*SUB_W +: SUB_W] : NOP;
  end

  assign acc_valid_o = acc_vld_raw & {N_EXEC{valid_q}};
  assign out_valid_o = valid_q;
  assign out_word_o  = word_q;
endmodule

// File: rtl/liw_expand_chk.sv
module liw_expand_chk
  import liw_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    stall_i,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic                    out_valid_o,
  input logic                    out_ready_i,
  input logic [WORD_W-1:0]       out_word_o,
  input logic [N_EXEC*SUB_W-1:0] exec_op_o,
  input logic [N_MEM*SUB_W-1:0]  mem_op_o,
  input logic [N_EXEC-1:0]       acc_valid_o,
  input logic [N_EXEC*ACC_W-1:0] acc_op_o
);
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !in_ready_o); // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(out_valid_o) && $stable(out_word_o) && $stable(exec_op_o)
             && $stable(mem_op_o) && $stable(acc_valid_o) && $stable(acc_op_o)); // R7

  AST_HOLD_UNTAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_word_o)
             && $stable(exec_op_o) && $stable(mem_op_o) && $stable(acc_op_o)); // R8

  AST_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R8

  AST_ACCEPT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R2

  AST_ACC_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acc_valid_o) |-> out_valid_o); // R4

  for (genvar k = 0; k < N_EXEC; k++) begin : g_excl
    AST_ACC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_valid_o[k] |-> exec_op_o[k*SUB_W +: SUB_W] == NOP); // R4
  end
endmodule

bind liw_expand liw_expand_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_i     (stall_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_word_o  (out_word_o),
  .exec_op_o   (exec_op_o),
  .mem_op_o    (mem_op_o),
  .acc_valid_o (acc_valid_o),
  .acc_op_o    (acc_op_o)
);

// File: tb/sim_liw_expand.sv
module sim_liw_expand;
  localparam int IDX_W = 8;
  localparam int DEPTH = 1 << IDX_W;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tbl_we = 1'b0;
  logic [IDX_W-1:0] tbl_waddr = '0;
  logic [95:0]  tbl_wdata = '0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_route = '0;
  logic [1:0]   cfg_pair = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [47:0]  in_word = '0;
  logic         stall = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [47:0]  out_word;
  logic [63:0]  exec_op;
  logic [31:0]  mem_op;
  logic [3:0]   acc_valid;
  logic [127:0] acc_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [95:0] shadow [DEPTH];

  always #5 clk = ~clk;

  liw_expand #(.IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tbl_we_i(tbl_we), .tbl_waddr_i(tbl_waddr), .tbl_wdata_i(tbl_wdata),
    .cfg_we_i(cfg_we), .cfg_route_i(cfg_route), .cfg_pair_i(cfg_pair),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_word_i(in_word),
    .stall_i(stall), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_word_o(out_word), .exec_op_o(exec_op), .mem_op_o(mem_op),
    .acc_valid_o(acc_valid), .acc_op_o(acc_op)
  );

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [95:0] pattern(input int i);
    logic [95:0] e;
    for (int k = 0; k < 6; k++)
      e[16*k +: 16] = 16'((i * 37 + k * 911 + 16'h05a3) ^ (k << 12));
    return e;
  endfunction

  // expected bundle from the requirements
  task automatic check_bundle(input string req, input logic [47:0] w, input logic [95:0] e,
                              input logic [3:0] r, input logic [1:0] p);
    logic [63:0]  x_exec;
    logic [31:0]  x_mem;
    logic [3:0]   x_av;
    logic [127:0] x_acc;
    x_exec = '0; x_mem = '0; x_av = '0; x_acc = '0;
    if (w[47]) begin
      x_mem = e[95:64];
      for (int k = 0; k < 4; k++) begin
        if (r[k]) begin x_av[k] = 1'b1; x_acc[32*k +: 32] = {16'h0, e[16*k +: 16]}; end
        else x_exec[16*k +: 16] = e[16*k +: 16];
      end
      for (int j = 0; j < 2; j++) begin
        if (p[j] && r[2*j]) begin
          x_acc[64*j +: 32] = {e[16*(2*j+1) +: 16], e[16*(2*j) +: 16]};
          x_acc[64*j+32 +: 32] = '0;
          x_av[2*j+1] = 1'b0;
          x_exec[16*(2*j+1) +: 16] = 16'h0;
        end
      end
    end
    chk(req, "out_valid", 128'(out_valid), 128'(1));
    chk(req, "out_word", 128'(out_word), 128'(w));
    chk(req, "exec_op", 128'(exec_op), 128'(x_exec));
    chk(req, "mem_op", 128'(mem_op), 128'(x_mem));
    chk(req, "acc_valid", 128'(acc_valid), 128'(x_av));
    chk(req, "acc_op", acc_op, x_acc);
  endtask

  task automatic tbl_write(input int i, input logic [95:0] e);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = IDX_W'(i); tbl_wdata = e;
    shadow[i] = e;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [3:0] r, input logic [1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_route = r; cfg_pair = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // present word for one edge; returns at the negedge after acceptance
  task automatic send(input logic [47:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [47:0] call_word(input int i, input int salt);
    return {1'b1, 39'(salt * 12345 + 77), 8'(i)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] w;
    logic [47:0] w2;
    int idx;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid", 128'(out_valid), 128'(0));
    chk("R1", "acc_valid", 128'(acc_valid), 128'(0));
    chk("R1", "in_ready", 128'(in_ready), 128'(1));
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after release", 128'(in_ready), 128'(1));

    for (int i = 0; i < DEPTH; i++) tbl_write(i, pattern(i));

    // R2 / R10: every index, upper word bits varying
    for (int i = 0; i < DEPTH; i++) begin
      w = call_word(i, i * 3 + 1);
      send(w);
      check_bundle("R2_R10", w, shadow[i], 4'h0, 2'h0);
    end

    // R3: plain words give NOP bundle
    for (int i = 0; i < 4; i++) begin
      w = {1'b0, 39'(i * 999 + 5), 8'(i * 60)};
      send(w);
      check_bundle("R3", w, shadow[i * 60], 4'h0, 2'h0);
    end

    // R4 / R5: all routing and join combinations
    for (int r = 0; r < 16; r++) begin
      for (int p = 0; p < 4; p++) begin
        set_cfg(4'(r), 2'(p));
        idx = (r * 4 + p) * 3;
        w = call_word(idx, r + p);
        send(w);
        check_bundle("R4_R5", w, shadow[idx], 4'(r), 2'(p));
      end
    end

    // R6 / R8: config change while held
    set_cfg(4'b0101, 2'b01);
    out_ready = 1'b0;
    w = call_word(17, 4);
    send(w);
    set_cfg(4'b1010, 2'b10);
    repeat (2) @(negedge clk);
    check_bundle("R6", w, shadow[17], 4'b0101, 2'b01);
    chk("R8", "in_ready while held", 128'(in_ready), 128'(0));
    // R9: table write during hold
    tbl_write(17, ~pattern(17));
    check_bundle("R9_hold", w, pattern(17), 4'b0101, 2'b01);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8", "out_valid after take", 128'(out_valid), 128'(0));
    send(w);
    check_bundle("R9_new", w, shadow[17], 4'b1010, 2'b10);

    // R7: stall freezes outputs and blocks input
    set_cfg(4'b0011, 2'b00);
    w = call_word(200, 9);
    send(w);
    stall = 1'b1;
    w2 = call_word(201, 10);
    in_valid = 1'b1; in_word = w2;
    #1;
    chk("R7", "in_ready under stall", 128'(in_ready), 128'(0));
    repeat (3) @(negedge clk);
    check_bundle("R7", w, shadow[200], 4'b0011, 2'b00);
    stall = 1'b0;
    #1;
    chk("R8", "in_ready after stall", 128'(in_ready), 128'(1));
    @(negedge clk);
    in_valid = 1'b0;
    check_bundle("R7_R8", w2, shadow[201], 4'b0011, 2'b00);
    @(negedge clk);
    chk("R8", "drained", 128'(out_valid), 128'(0));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule